// File: doc/BRIEF.md
# RTC Tick Prescaler with Selectable Reference

This block turns a slow reference clock, delivered into the system clock domain as one-cycle enable pulses, into a family of timing strobes for a real-time clock. It produces a once-per-second strobe and a vector of nine periodic strobes at 2, 4, 8, 16, 32, 64, 128, 256 and 512 Hz. The reference may run at 32768 Hz, 32000 Hz or 38400 Hz. Only the first of these is a power of two, so the block does not use a plain binary divider. A fractional phase accumulator adds 1024 for every reference pulse and subtracts the reference frequency each time it wraps. This yields exactly 1024 base events for every second of reference pulses. A 10-bit binary counter then subdivides the base events into the slower rates.

A two-state controller governs the dividers. In `ST_IDLE`, the accumulator and the counter are held at zero, and the reference selection is captured. The `START` transition moves to `ST_RUN` once the block is enabled and the selection is valid. In `ST_RUN`, each reference pulse advances the accumulator. The `HALT` transition returns to `ST_IDLE` in three cases: enable drops, the invalid selection is chosen, or the selection differs from the captured one. Every divider clears in the same cycle that `HALT` is taken.

Top module: `rtc_tick_prescaler`

## Requirements
- R1: `ref_sel` encodes the reference frequency: 0 = 32768 Hz, 1 = 32000 Hz, 2 = 38400 Hz. Starting from a cleared state, exactly one reference second (that many pulses) yields exactly 1024 base events.
- R2: `rate_tick[k]` strobes at 2^(k+1) Hz, so bit 0 is 2 Hz and bit 8 is 512 Hz. Whenever a slower bit strobes, every faster bit strobes in the same cycle.
- R3: `sec_tick` strobes once per reference second, on the last pulse of that second. It always coincides with a `rate_tick[0]` strobe, which happens on every second 2 Hz event.
- R4: Every strobe lasts exactly one system clock. A strobe appears only in the clock after a cycle in which `ref_pulse` was high; there is one register of latency.
- R5: The strobe pattern for each pulse follows exactly from the cumulative accumulator arithmetic. No event is dropped, doubled or shifted, including with idle cycles between pulses.
- R6: `ref_sel` = 3 is invalid: while it is selected, no strobe is produced and pulses are ignored.
- R7: While `enable` is low, no strobe is produced and all dividers are held at zero. After re-enabling, the first second's strobe lands on exactly the F-th pulse.
- R8: A change of `ref_sel` while running clears the dividers and restarts the phase from zero under the new reference.
- R9: While reset is asserted and right after it, all strobe outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | One-cycle pulse per reference clock edge |
| enable | input | 1 | Run enable; low clears all dividers |
| ref_sel | input | 2 | Reference frequency select |
| sec_tick | output | 1 | One-cycle 1 Hz strobe |
| rate_tick | output | 9 | One-cycle periodic strobes, bit k at 2^(k+1) Hz |

## Verification
The bench builds the block with its default parameters: a 1024 Hz base event and a 10-bit subdivision counter, which gives nine taps. With these values a full reference second at each of the three frequencies fits in the run. The bench can therefore count every tap over a whole second and confirm the exact 512/256/.../2/1 totals, not just the strobe spacing. The base rate is small enough that the scoreboard replays the accumulator pulse by pulse. This exposes any drift across the non-power-of-two wraps, and it catches restarts that disable or a change of reference fails to perform.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
    localparam int unsigned BASE_HZ    = 1024;
    localparam int unsigned REF_MAX_HZ = 38400;
    localparam int unsigned ACC_W      = $clog2(REF_MAX_HZ + BASE_HZ) + 1;

    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} tick_state_e;
    typedef logic [1:0] ref_sel_t;

    // Reference frequency in Hz for each select code; code 3 has none.
    function automatic logic [ACC_W-1:0] ref_hz(input ref_sel_t sel);
        logic [ACC_W-1:0] hz;
        case (sel)
            2'd0:    hz = ACC_W'(32768);
            2'd1:    hz = ACC_W'(32000);
            2'd2:    hz = ACC_W'(38400);
            default: hz = '0;
        endcase
        return hz;
    endfunction

    function automatic logic sel_valid(input ref_sel_t sel);
        return sel != 2'd3;
    endfunction
endpackage

// File: rtl/rtc_phase_acc.sv
module rtc_phase_acc #(
    parameter int unsigned W   = rtc_tick_pkg::ACC_W,
    parameter int unsigned INC = rtc_tick_pkg::BASE_HZ
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] modulus,
    output logic         base_evt
);
    logic [W-1:0] acc_q;
    logic [W-1:0] sum;

    assign sum      = acc_q + W'(INC);
    assign base_evt = step && (sum >= modulus);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= base_evt ? (sum - modulus) : sum;
        end
    end
endmodule

// File: rtl/rtc_tap_divider.sv
module rtc_tap_divider #(
    parameter int unsigned CNT_W    = 10,
    parameter int unsigned NUM_TAPS = CNT_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                adv,
    output logic                sec_hit,
    output logic [NUM_TAPS-1:0] tap_hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    assign cnt_nxt = cnt_q + 1'b1;
    assign sec_hit = adv && (cnt_nxt == '0);

    // Tap k divides the base event by 2^(CNT_W-1-k).
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        localparam int unsigned LOW = CNT_W - 1 - k;
        assign tap_hit[k] = adv && (cnt_nxt[LOW-1:0] == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_nxt;
        end
    end
endmodule

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler
    import rtc_tick_pkg::*;
#(
    parameter int unsigned CNT_W    = $clog2(rtc_tick_pkg::BASE_HZ),
    parameter int unsigned NUM_TAPS = CNT_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_pulse,
    input  logic                enable,
    input  logic [1:0]          ref_sel,
    output logic                sec_tick,
    output logic [NUM_TAPS-1:0] rate_tick
);
    tick_state_e         state_q, state_d;
    ref_sel_t            sel_q;
    logic                cfg_ok;
    logic                active;
    logic                base_evt;
    logic                sec_hit;
    logic [NUM_TAPS-1:0] tap_hit;

    assign cfg_ok = enable && sel_valid(ref_sel);
    assign active = (state_q == ST_RUN) && cfg_ok && (ref_sel == sel_q);

    // Next state: START and HALT transitions.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = cfg_ok ? ST_RUN : ST_IDLE;
            ST_RUN:  state_d = active ? ST_RUN : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs and captured selection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= 2'd0;
            sec_tick  <= 1'b0;
            rate_tick <= '0;
        end else begin
            if (state_q == ST_IDLE) sel_q <= ref_sel;
            sec_tick  <= active && sec_hit;
            rate_tick <= active ? tap_hit : '0;
        end
    end

    rtc_phase_acc #(
        .W   (ACC_W),
        .INC (BASE_HZ)
    ) u_phase_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!active),
        .step     (active && ref_pulse),
        .modulus  (ref_hz(sel_q)),
        .base_evt (base_evt)
    );

    rtc_tap_divider #(
        .CNT_W    (CNT_W),
        .NUM_TAPS (NUM_TAPS)
    ) u_tap_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!active),
        .adv     (base_evt),
        .sec_hit (sec_hit),
        .tap_hit (tap_hit)
    );
endmodule

// File: rtl/rtc_tick_checker.sv
module rtc_tick_checker #(
    parameter int unsigned NUM_TAPS = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ref_pulse,
    input logic                enable,
    input logic [1:0]          ref_sel,
    input logic                sec_tick,
    input logic [NUM_TAPS-1:0] rate_tick
);
    p_strobe_after_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick || (|rate_tick)) |-> $past(ref_pulse));

    p_fast_tap_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rate_tick[NUM_TAPS-1] |=> !rate_tick[NUM_TAPS-1]);

    p_sec_with_2hz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> rate_tick[0]);

    for (genvar k = 0; k + 1 < NUM_TAPS; k++) begin : g_nest
        p_tap_nesting_r2: assert property (@(posedge clk) disable iff (!rst_n)
            rate_tick[k] |-> rate_tick[k+1]);
    end

    p_invalid_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_sel == 2'd3) |=> (!sec_tick && (rate_tick == '0)));

    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sec_tick && (rate_tick == '0)));

    p_sel_change_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_sel != $past(ref_sel)) |=> (!sec_tick && (rate_tick == '0)));
endmodule

bind rtc_tick_prescaler rtc_tick_checker #(.NUM_TAPS(NUM_TAPS)) u_rtc_tick_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_pulse (ref_pulse),
    .enable    (enable),
    .ref_sel   (ref_sel),
    .sec_tick  (sec_tick),
    .rate_tick (rate_tick)
);

// File: tb/test_rtc_tick_prescaler.sv
module test_rtc_tick_prescaler;
    localparam int NT = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_pulse = 1'b0;
    logic          enable = 1'b0;
    logic [1:0]    ref_sel = 2'd0;
    logic          sec_tick;
    logic [NT-1:0] rate_tick;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NT:0] exp_q[$];
    int m_acc, m_cnt, m_f;
    bit m_active;
    int sec_tally;
    int rate_tally[NT];

    always #4 clk = ~clk;

    rtc_tick_prescaler i_rtc_tick_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .enable    (enable),
        .ref_sel   (ref_sel),
        .sec_tick  (sec_tick),
        .rate_tick (rate_tick)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_tallies();
        sec_tally = 0;
        for (int k = 0; k < NT; k++) rate_tally[k] = 0;
    endtask

    // Driver: one reference pulse, expected item pushed to the scoreboard.
    task automatic pulse();
        logic [NT:0] e;
        @(posedge clk); #2;
        ref_pulse = 1'b1;
        e = '0;
        if (m_active) begin
            m_acc = m_acc + 1024;
            if (m_acc >= m_f) begin
                m_acc = m_acc - m_f;
                m_cnt = (m_cnt + 1) % 1024;
                e[NT] = (m_cnt == 0);
                for (int k = 0; k < NT; k++)
                    e[k] = ((m_cnt % (1 << (NT - k))) == 0);
            end
        end
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(posedge clk); #2;
        ref_pulse = 1'b0;
    endtask

    task automatic run(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            pulse();
            if (gap != 0 && (i % gap) == gap - 1) idle();
        end
        idle();
        idle();
    endtask

    task automatic configure(input bit en, input logic [1:0] sel);
        @(posedge clk); #2;
        ref_pulse = 1'b0;
        enable = en;
        ref_sel = sel;
        repeat (3) @(posedge clk);
        #2;
        m_acc = 0;
        m_cnt = 0;
        m_active = en && (sel != 2'd3);
        case (sel)
            2'd0:    m_f = 32768;
            2'd1:    m_f = 32000;
            2'd2:    m_f = 38400;
            default: m_f = 1;
        endcase
        clear_tallies();
    endtask

    task automatic check_second(input string tag);
        check(sec_tally == 1, {tag, " R3 seconds"}, sec_tally, 1);
        for (int k = 0; k < NT; k++)
            check(rate_tally[k] == (2 << k), {tag, " R2 tap count"}, rate_tally[k], 2 << k);
        check(rate_tally[NT-1] == 512, {tag, " R1 base events/2"}, rate_tally[NT-1], 512);
    endtask

    task automatic check_quiet(input string tag);
        int tot;
        tot = sec_tally;
        for (int k = 0; k < NT; k++) tot += rate_tally[k];
        check(tot == 0, tag, tot, 0);
    endtask

    // Monitor: pops one expected item per pulse, else expects silence (R4).
    initial begin
        bit pend = 0;
        logic [NT:0] obs, e;
        forever begin
            @(negedge clk);
            obs = {sec_tick, rate_tick};
            if (pend) begin
                e = exp_q.pop_front();
                check(obs == e, "R5 strobe pattern", int'(obs), int'(e));
                if (obs[NT]) sec_tally++;
                for (int k = 0; k < NT; k++) if (obs[k]) rate_tally[k]++;
            end else if (rst_n) begin
                check(obs == '0, "R4 strobe without pulse", int'(obs), 0);
            end
            pend = ref_pulse;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_active = 0; m_acc = 0; m_cnt = 0; m_f = 1;
        clear_tallies();
        repeat (4) @(posedge clk);
        #2;
        check(sec_tick == 1'b0 && rate_tick == '0, "R9 outputs in reset",
              int'({sec_tick, rate_tick}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sec_tick == 1'b0 && rate_tick == '0, "R9 outputs after reset",
              int'({sec_tick, rate_tick}), 0);

        // R1/R2/R3: full second at 32768 Hz, back-to-back pulses.
        configure(1, 2'd0);
        run(32768, 0);
        check_second("R1 sel0");

        // R8: run partway, then switch reference; phase restarts.
        configure(1, 2'd0);
        run(5000, 0);
        configure(1, 2'd1);
        run(32000, 7);
        check_second("R8 sel1 after switch");

        // R7: run, disable, confirm silence, re-enable with fresh phase.
        configure(1, 2'd2);
        run(10000, 0);
        configure(0, 2'd2);
        run(3000, 0);
        check_quiet("R7 disabled strobes");
        configure(1, 2'd2);
        run(38399, 0);
        check(sec_tally == 0, "R7 no second before F-th pulse", sec_tally, 0);
        run(1, 0);
        check_second("R7 sel2 after re-enable");

        // R6: invalid select ignores pulses.
        configure(1, 2'd3);
        run(2000, 3);
        check_quiet("R6 invalid select strobes");

        repeat (3) @(posedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule